// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Arbitration

This block keeps a decode stage supplied with instruction bytes. It holds a 16-byte first-in first-out store of code bytes and a code fetch pointer. While the store has room for a whole 32-bit word, it fetches the next sequential word from memory. The decode stage removes bytes one at a time whenever it is ready.

The single memory bus is shared with an execution stage that issues data operand reads and writes. The block decides who owns the bus only when no bus cycle is in progress. A waiting data request always wins over a code fetch. When the store cannot take another word and no data request is waiting, the bus stays idle.

A branch is signalled with a one-cycle flush pulse that carries a new fetch pointer. The flush empties the store and reloads the pointer. A code fetch that is already on the bus still runs to its acknowledge, but its word is thrown away.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset `byteValid` and `memReq` are low, and the first code fetch uses address `RESET_PTR` (default 0).
- R2: The store never holds more than 16 bytes. Once it is full, the bytes already in it stay intact and stay in order until they are popped.
- R3: From idle, with no data request, no flush, and at least 4 free byte slots, a code fetch starts on the next cycle at the fetch pointer. The pointer advances by 4 after each code fetch whose word is kept.
- R4: A fetched word enters the store lowest address first: `memRdata[7:0]` first, then `[15:8]`, then `[23:16]`, then `[31:24]`.
- R5: `byteValid` is high whenever the store is not empty, and `byteOut` is the oldest byte. A byte is removed in a cycle where `popReady` and `byteValid` are both high.
- R6: When the bus is idle and `dReq` is high, a data cycle starts on the next cycle, ahead of any code fetch. It drives `dAddr`, `dWrite` and `dWdata` onto the bus. `dDone` is high in the cycle of `memAck`, with `dRdata` equal to `memRdata`. The execution stage drops `dReq` in the cycle after `dDone`.
- R7: Once `memReq` rises, it stays high with a stable address and write flag until `memAck`. There is at least one idle cycle between bus cycles, and arbitration happens only in that idle cycle.
- R8: If fewer than 4 bytes are free and no data request is waiting, no bus cycle is started.
- R9: A flush empties the store in that cycle, including any byte popped in the same cycle. It loads the fetch pointer from `flushPtr` with the two low bits cleared, and no code fetch starts in that cycle.
- R10: The word of a code fetch that is in flight when a flush arrives, or that is acknowledged in the flush cycle, is discarded. The fetch pointer then keeps its flushed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| popReady | input | 1 | Decode stage takes the head byte this cycle |
| byteValid | output | 1 | Store is not empty |
| byteOut | output | 8 | Oldest byte in the store |
| flush | input | 1 | Branch: empty the store and reload the pointer |
| flushPtr | input | 32 | New code fetch pointer |
| dReq | input | 1 | Data operand access request |
| dAddr | input | 32 | Data access address |
| dWrite | input | 1 | Data access is a write |
| dWdata | input | 32 | Data write value |
| dDone | output | 1 | Data access completes this cycle |
| dRdata | output | 32 | Data read value |
| memReq | output | 1 | Bus cycle in progress |
| memAddr | output | 32 | Bus address |
| memWrite | output | 1 | Bus cycle is a write |
| memWdata | output | 32 | Bus write data |
| memAck | input | 1 | Memory completes the bus cycle |
| memRdata | input | 32 | Memory read data |

## Verification
The block is first run with no pops and no data traffic, which shows whether filling stops at exactly 16 bytes and the bus goes quiet. It is then run with constant pops and zero-latency memory, which separates the correct byte order within a word from a swapped lane order. Random pops, random data requests and random latency follow, and show whether data always wins in the idle cycle and whether bus cycles are ever cut short. Random flushes, some landing while a code fetch is in flight, show whether stale words are dropped and the fetch pointer is reloaded. A final pass keeps the store full while data requests keep arriving, to confirm that data cycles still get the bus.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_CODE = 2'd1,
    BUS_DATA = 2'd2
  } busKind_t;

  typedef struct packed {
    logic startCode;
    logic startData;
    logic pushWord;
    logic clearQueue;
  } pfqStrobe_t;
endpackage

// File: rtl/pfq_control.sv
module pfq_control
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dReq,
  input  logic       memAck,
  input  logic       flush,
  input  logic       roomForWord,
  output pfqStrobe_t strobe,
  output logic       memReq,
  output logic       dDone
);
  busKind_t state;
  logic     discard;
  logic     idle;

  assign idle = (state == BUS_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.startData  = idle && dReq;
    strobe.startCode  = idle && !dReq && !flush && roomForWord;
    strobe.pushWord   = (state == BUS_CODE) && memAck && !discard && !flush;
    strobe.clearQueue = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= BUS_IDLE;
      discard <= 1'b0;
    end else begin
      case (state)
        BUS_IDLE: begin
          if (strobe.startData)      state <= BUS_DATA;
          else if (strobe.startCode) state <= BUS_CODE;
        end
        BUS_CODE: begin
          if (memAck) begin
            state   <= BUS_IDLE;
            discard <= 1'b0;
          end else if (flush) begin
            discard <= 1'b1;
          end
        end
        BUS_DATA: if (memAck) state <= BUS_IDLE;
        default:  state <= BUS_IDLE;
      endcase
    end
  end

  assign memReq = !idle;
  assign dDone  = (state == BUS_DATA) && memAck;

  // R7: a started bus cycle is held until acknowledged
  a_r7_hold_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R6: a waiting data request owns the next bus cycle
  a_r6_data_first: assert property (@(posedge clk) disable iff (!rstN)
    (idle && dReq) |=> (state == BUS_DATA));
  // R8: no room and no data request keeps the bus quiet
  a_r8_idle_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !dReq && !roomForWord) |=> !memReq);
  // R10: a fetch overtaken by a flush never writes the store
  a_r10_drop_stale: assert property (@(posedge clk) disable iff (!rstN)
    ((state == BUS_CODE) && flush && !memAck) |=> !strobe.pushWord);
endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 16,
  parameter int          WORD_BYTES = 4,
  parameter int          AW         = 32,
  parameter logic [31:0] RESET_PTR  = 32'h0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pfqStrobe_t              strobe,
  input  logic                    popReady,
  input  logic [AW-1:0]           flushPtr,
  input  logic [AW-1:0]           dAddr,
  input  logic                    dWrite,
  input  logic [8*WORD_BYTES-1:0] dWdata,
  input  logic [8*WORD_BYTES-1:0] memRdata,
  output logic                    roomForWord,
  output logic                    byteValid,
  output logic [7:0]              byteOut,
  output logic [AW-1:0]           memAddr,
  output logic                    memWriteReg,
  output logic [8*WORD_BYTES-1:0] memWdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LOW_W = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << LOW_W) - 1);

  logic [7:0]       qMem [DEPTH];
  logic [7:0]       lane [WORD_BYTES];
  logic [PTR_W-1:0] rdIdx, wrIdx;
  logic [CNT_W-1:0] count, countNext;
  logic [AW-1:0]    fetchPtr;
  logic             popFire;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign lane[b] = memRdata[8*b +: 8];
  end

  assign byteValid   = (count != '0);
  assign byteOut     = qMem[rdIdx];
  assign roomForWord = (count <= CNT_W'(DEPTH - WORD_BYTES));
  assign popFire     = popReady && byteValid && !strobe.clearQueue;

  always_comb begin
    countNext = count;
    if (strobe.clearQueue) countNext = '0;
    else begin
      if (strobe.pushWord) countNext = countNext + CNT_W'(WORD_BYTES);
      if (popFire)         countNext = countNext - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushWord)
      for (int b = 0; b < WORD_BYTES; b++) qMem[wrIdx + PTR_W'(b)] <= lane[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx    <= '0;
      wrIdx    <= '0;
      count    <= '0;
      fetchPtr <= RESET_PTR[AW-1:0];
    end else begin
      count <= countNext;
      if (strobe.clearQueue) begin
        rdIdx    <= '0;
        wrIdx    <= '0;
        fetchPtr <= flushPtr & ALIGN_MASK;
      end else begin
        if (popFire) rdIdx <= rdIdx + PTR_W'(1);
        if (strobe.pushWord) begin
          wrIdx    <= wrIdx + PTR_W'(WORD_BYTES);
          fetchPtr <= fetchPtr + AW'(WORD_BYTES);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr     <= '0;
      memWriteReg <= 1'b0;
      memWdata    <= '0;
    end else if (strobe.startData) begin
      memAddr     <= dAddr;
      memWriteReg <= dWrite;
      memWdata    <= dWdata;
    end else if (strobe.startCode) begin
      memAddr     <= fetchPtr;
      memWriteReg <= 1'b0;
    end
  end

  // R2: occupancy never passes capacity
  a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R9: a flush leaves the store empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearQueue |=> (count == '0));
  // R3: kept fetch advances the pointer by one word
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushWord |=> (fetchPtr == $past(fetchPtr) + AW'(WORD_BYTES)));
  // R6: a data cycle carries the requester's address and direction
  a_r6_data_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startData |=> (memAddr == $past(dAddr)) && (memWriteReg == $past(dWrite)));
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 16,
  parameter int          WORD_BYTES = 4,
  parameter int          AW         = 32,
  parameter logic [31:0] RESET_PTR  = 32'h0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    popReady,
  output logic                    byteValid,
  output logic [7:0]              byteOut,
  input  logic                    flush,
  input  logic [AW-1:0]           flushPtr,
  input  logic                    dReq,
  input  logic [AW-1:0]           dAddr,
  input  logic                    dWrite,
  input  logic [8*WORD_BYTES-1:0] dWdata,
  output logic                    dDone,
  output logic [8*WORD_BYTES-1:0] dRdata,
  output logic                    memReq,
  output logic [AW-1:0]           memAddr,
  output logic                    memWrite,
  output logic [8*WORD_BYTES-1:0] memWdata,
  input  logic                    memAck,
  input  logic [8*WORD_BYTES-1:0] memRdata
);
  pfqStrobe_t strobe;
  logic       roomForWord;
  logic       memWriteReg;

  pfq_control u_ctrl (
    .clk(clk), .rstN(rstN), .dReq(dReq), .memAck(memAck), .flush(flush),
    .roomForWord(roomForWord), .strobe(strobe), .memReq(memReq), .dDone(dDone)
  );

  pfq_datapath #(
    .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .AW(AW), .RESET_PTR(RESET_PTR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .popReady(popReady),
    .flushPtr(flushPtr), .dAddr(dAddr), .dWrite(dWrite), .dWdata(dWdata),
    .memRdata(memRdata), .roomForWord(roomForWord), .byteValid(byteValid),
    .byteOut(byteOut), .memAddr(memAddr), .memWriteReg(memWriteReg),
    .memWdata(memWdata)
  );

  assign memWrite = memReq && memWriteReg;
  assign dRdata   = memRdata;
endmodule

// File: tb/instr_prefetch_queue_tb.sv
`timescale 1ns/1ps
module instr_prefetch_queue_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        popReady = 1'b0, flush = 1'b0, dReq = 1'b0, dWrite = 1'b0, memAck = 1'b0;
  logic [31:0] flushPtr = '0, dAddr = '0, dWdata = '0, memRdata = '0;
  logic        byteValid, dDone, memReq, memWrite;
  logic [7:0]  byteOut;
  logic [31:0] dRdata, memAddr, memWdata;

  always #10 clk = ~clk;

  instr_prefetch_queue dut_i (
    .clk(clk), .rstN(rstN), .popReady(popReady), .byteValid(byteValid),
    .byteOut(byteOut), .flush(flush), .flushPtr(flushPtr), .dReq(dReq),
    .dAddr(dAddr), .dWrite(dWrite), .dWdata(dWdata), .dDone(dDone),
    .dRdata(dRdata), .memReq(memReq), .memAddr(memAddr), .memWrite(memWrite),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int tests = 0, fails = 0;
  bit running = 0, finished = 0;
  int popPct = 0, dataPct = 0, flushPct = 0, latMax = 0, waitCnt = 0;

  // reference model state
  byte unsigned q[$];
  int          kind = 0;            // 0 idle, 1 code, 2 data
  logic [31:0] mAddr = '0, mPtr = '0, mWd = '0;
  bit          mWr = 0, mDiscard = 0, dataFinished = 0, flushedLast = 0, codeAfterFlush = 0;

  function automatic logic [7:0] memByte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] memWord(logic [31:0] a);
    return {memByte(a + 3), memByte(a + 2), memByte(a + 1), memByte(a)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int  size0;
    bit  pop;
    if (!rstN) begin
      q.delete(); kind = 0; mAddr = '0; mPtr = '0; mWr = 0; mWd = '0;
      mDiscard = 0; dataFinished = 0; flushedLast = 0; codeAfterFlush = 0;
    end else if (running) begin
      size0 = q.size();
      pop   = popReady && (size0 > 0);
      flushedLast = flush;
      if (flush) begin
        q.delete();
        mPtr = flushPtr & 32'hFFFF_FFFC;
        if (kind == 1) begin
          codeAfterFlush = 1;
          if (memAck) begin kind = 0; mDiscard = 0; end
          else mDiscard = 1;
        end else if (kind == 2 && memAck) begin
          kind = 0; dataFinished = 1;
        end else if (kind == 0 && dReq) begin
          kind = 2; mAddr = dAddr; mWr = dWrite; mWd = dWdata;
        end
      end else begin
        if (pop) void'(q.pop_front());
        if (kind == 1 && memAck) begin
          if (!mDiscard) begin
            for (int b = 0; b < 4; b++) q.push_back(memByte(mAddr + b));
            mPtr = mPtr + 4;
            codeAfterFlush = 0;
          end
          mDiscard = 0; kind = 0;
        end else if (kind == 2 && memAck) begin
          kind = 0; dataFinished = 1;
        end else if (kind == 0) begin
          if (dReq) begin
            kind = 2; mAddr = dAddr; mWr = dWrite; mWd = dWdata;
          end else if (size0 <= 12) begin
            kind = 1; mAddr = mPtr; mWr = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      // memory responder
      if (kind == 0) begin
        memAck  = 0;
        waitCnt = (latMax == 0) ? 0 : $urandom_range(latMax, 0);
      end else if (waitCnt > 0) begin
        memAck = 0; waitCnt--;
      end else begin
        memAck = 1;
      end
      memRdata = memWord(mAddr);
      // execution stage
      if (dataFinished) begin
        dReq = 0; dataFinished = 0;
      end else if (!dReq && $urandom_range(99, 0) < dataPct) begin
        dReq = 1; dAddr = $urandom; dWrite = $urandom_range(1, 0); dWdata = $urandom;
      end
      popReady = $urandom_range(99, 0) < popPct;
      flush    = $urandom_range(99, 0) < flushPct;
      flushPtr = $urandom;
      #1;
      chk((kind == 0 && q.size() > 12) ? "R8 memReq" : "R7 memReq", memReq, kind != 0);
      if (kind != 0)
        chk(kind == 1 ? (codeAfterFlush ? "R10 memAddr" : "R3 memAddr") : "R6 memAddr",
            memAddr, mAddr);
      chk("R6 memWrite", memWrite, kind == 2 && mWr);
      if (kind == 2 && mWr) chk("R6 memWdata", memWdata, mWd);
      chk(flushedLast ? "R9 byteValid" : "R5 byteValid", byteValid, q.size() > 0);
      if (q.size() > 0) chk(q.size() == 16 ? "R2 byteOut" : "R4 byteOut", byteOut, q[0]);
      chk("R6 dDone", dDone, kind == 2 && memAck);
      if (kind == 2 && memAck) chk("R6 dRdata", dRdata, memRdata);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 memReq", memReq, 0);
    chk("R1 byteValid", byteValid, 0);
    @(negedge clk); rstN = 1; running = 1;
    // fill without pops: capacity and quiet bus
    repeat (60) @(posedge clk);
    // steady draining, zero latency
    popPct = 100; latMax = 0;
    repeat (200) @(posedge clk);
    // mixed traffic
    popPct = 60; dataPct = 20; latMax = 3;
    repeat (800) @(posedge clk);
    // branches
    flushPct = 8; latMax = 4;
    repeat (1500) @(posedge clk);
    // full store under data pressure
    flushPct = 0; popPct = 0; dataPct = 40; latMax = 2;
    repeat (400) @(posedge clk);
    popPct = 30; flushPct = 3; dataPct = 10;
    repeat (600) @(posedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule